// File: doc/BRIEF.md
# Ranked Slot Interrupt Winner Resolver

This block picks, from a programmable ranking table, the most urgent interrupt source that is currently live. Each entry of the table (a "slot") names one source by its 6-bit ID and carries a valid flag. Slot 0 is the most urgent rank, and urgency falls as the slot index rises. Urgency therefore comes from where software places an ID in the table, not from the ID value itself.

Two winners are resolved in parallel: one among sources steered to the fast interrupt class (FIQ) and one among sources steered to the normal class (IRQ). Both results are packed into one 32-bit status word, which is registered and updates one clock after the inputs. The table storage, the pending and enable registers and the bus access all sit outside the block. The pending-and-enabled vector and the steering vector come in ready-made.

Top module: `prio_slot_resolver`

## Requirements
- R1: A slot takes part only when its valid flag is 1 and its ID is below NUM_SRC (40). A slot with its flag clear, or with an ID of 40 to 63, is skipped.
- R2: Among the slots that qualify for one class, the lowest slot index wins. The two classes are resolved independently. When one ID sits in several valid slots, the lowest of those slots sets its rank.
- R3: A slot qualifies for FIQ when bit ID of pend_en_i is 1 and bit ID of fiq_sel_i is 1. It qualifies for IRQ when bit ID of pend_en_i is 1 and bit ID of fiq_sel_i is 0.
- R4: FIQ half of status_o: bit 15 is 1 when a FIQ winner exists, and bits 5:0 then hold its ID.
- R5: IRQ half of status_o: bit 31 is 1 when an IRQ winner exists, and bits 21:16 then hold its ID.
- R6: A half with no winner has its flag bit at 0 and its ID field at 6'h3F. With no winner at all, status_o is 32'h003F003F.
- R7: Bits 14:6 and 30:22 of status_o are always 0.
- R8: status_o holds 32'h003F003F while rst_ni is low. Otherwise it shows the result for the inputs sampled at the previous rising edge of clk_i, and it does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_valid_i | input | NUM_SLOTS (40) | Valid flag per slot; bit k belongs to slot k |
| slot_id_i | input | NUM_SLOTS*6 (240) | Source ID per slot; slot k at bits 6k+5:6k |
| pend_en_i | input | NUM_SRC (40) | Per source: pending and enabled |
| fiq_sel_i | input | NUM_SRC (40) | Per source: 1 steers it to FIQ, 0 to IRQ |
| status_o | output | 32 | Packed FIQ and IRQ winners, registered |

## Verification
Every result is due one rising edge after the inputs that produce it. The bench changes the inputs on a falling edge, lets one rising edge pass, and reads status_o on the next falling edge. For R8, it also reads status_o just after a change of inputs, before the next rising edge, and expects the old word to be still there. Directed scenarios have hand-computed words. A run of random tables is compared against a slot-scanning model written in the bench, and that model reads the inputs held over the same edge.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int unsigned ID_W      = 6;
  localparam int unsigned STAT_W    = 32;
  localparam logic [ID_W-1:0] NO_ID = 6'h3F;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic            fiq_found,
    input logic [ID_W-1:0] fiq_id,
    input logic            irq_found,
    input logic [ID_W-1:0] irq_id
  );
    pack_status = {irq_found, 9'd0, irq_id, fiq_found, 9'd0, fiq_id};
  endfunction

  localparam logic [STAT_W-1:0] IDLE_WORD = {1'b0, 9'd0, NO_ID, 1'b0, 9'd0, NO_ID};
endpackage

// File: rtl/prs_slot_qualify.sv
module prs_slot_qualify
  import prs_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 40,
  parameter int unsigned NUM_SRC   = 40
) (
  input  logic [NUM_SLOTS-1:0]      slot_valid_i,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_id_i,
  input  logic [NUM_SRC-1:0]        pend_en_i,
  input  logic [NUM_SRC-1:0]        fiq_sel_i,
  output logic [NUM_SLOTS-1:0]      fiq_hit_o,
  output logic [NUM_SLOTS-1:0]      irq_hit_o
);
  localparam int unsigned TAB_W = 1 << ID_W;

  // widen to the full ID space so out-of-range IDs read as not live
  logic [TAB_W-1:0] pend_tab, fiq_tab;
  assign pend_tab = TAB_W'(pend_en_i);
  assign fiq_tab  = TAB_W'(fiq_sel_i);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [ID_W-1:0] id;
    logic            live;
    assign id   = slot_id_i[g*ID_W +: ID_W];
    assign live = slot_valid_i[g] && (id < ID_W'(NUM_SRC)) && pend_tab[id];
    assign fiq_hit_o[g] = live &  fiq_tab[id];
    assign irq_hit_o[g] = live & ~fiq_tab[id];
  end
endmodule

// File: rtl/prs_first_pick.sv
module prs_first_pick
  import prs_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 40
) (
  input  logic [NUM_SLOTS-1:0]      hit_i,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_id_i,
  output logic                      found_o,
  output logic [ID_W-1:0]           id_o
);
  // scan from the lowest rank upward so slot 0 is written last
  always_comb begin
    found_o = 1'b0;
    id_o    = NO_ID;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        found_o = 1'b1;
        id_o    = slot_id_i[i*ID_W +: ID_W];
      end
    end
  end
endmodule

// File: rtl/prio_slot_resolver.sv
module prio_slot_resolver
  import prs_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 40,
  parameter int unsigned NUM_SRC   = 40
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SLOTS-1:0]        slot_valid_i,
  input  logic [NUM_SLOTS*ID_W-1:0]   slot_id_i,
  input  logic [NUM_SRC-1:0]          pend_en_i,
  input  logic [NUM_SRC-1:0]          fiq_sel_i,
  output logic [STAT_W-1:0]           status_o
);
  localparam int unsigned TAB_W = 1 << ID_W;

  logic [NUM_SLOTS-1:0] fiq_hit, irq_hit;
  logic                 fiq_found, irq_found;
  logic [ID_W-1:0]      fiq_id, irq_id;

  prs_slot_qualify #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC)) u_qual (
    .slot_valid_i (slot_valid_i),
    .slot_id_i    (slot_id_i),
    .pend_en_i    (pend_en_i),
    .fiq_sel_i    (fiq_sel_i),
    .fiq_hit_o    (fiq_hit),
    .irq_hit_o    (irq_hit)
  );

  prs_first_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick_fiq (
    .hit_i     (fiq_hit),
    .slot_id_i (slot_id_i),
    .found_o   (fiq_found),
    .id_o      (fiq_id)
  );

  prs_first_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick_irq (
    .hit_i     (irq_hit),
    .slot_id_i (slot_id_i),
    .found_o   (irq_found),
    .id_o      (irq_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= IDLE_WORD;
    else         status_o <= pack_status(fiq_found, fiq_id, irq_found, irq_id);
  end

  // R3: a reported winner was live and steered to its class one edge earlier
  a_r3_fiq_winner_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15] |-> (((TAB_W'($past(pend_en_i & fiq_sel_i))) >> status_o[5:0]) & TAB_W'(1)) == TAB_W'(1));
  a_r3_irq_winner_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[31] |-> (((TAB_W'($past(pend_en_i & ~fiq_sel_i))) >> status_o[21:16]) & TAB_W'(1)) == TAB_W'(1));
  // R1: reported IDs are in range
  a_r1_fiq_id_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15] |-> (status_o[5:0] < ID_W'(NUM_SRC)));
  a_r1_irq_id_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[31] |-> (status_o[21:16] < ID_W'(NUM_SRC)));
  // R6: empty halves read the idle code
  a_r6_fiq_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[15] |-> (status_o[5:0] == NO_ID));
  a_r6_irq_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[31] |-> (status_o[21:16] == NO_ID));
  // R7: gap bits stay clear
  a_r7_zero_gaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[14:6] == '0) && (status_o[30:22] == '0));
  // R8: output only follows registered inputs
  a_r8_held_when_inputs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(slot_valid_i) && $stable(slot_id_i) && $stable(pend_en_i) && $stable(fiq_sel_i))
      |=> $stable(status_o));
endmodule

// File: tb/tb_prio_slot_resolver.sv
module tb_prio_slot_resolver;
  localparam int NS = 40;
  localparam int NR = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS-1:0]     vld = '0;
  logic [NS*6-1:0]   ids = '0;
  logic [NR-1:0]     pend = '0;
  logic [NR-1:0]     fsel = '0;
  logic [31:0]       status;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  prio_slot_resolver #(.NUM_SLOTS(NS), .NUM_SRC(NR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .slot_valid_i(vld), .slot_id_i(ids),
    .pend_en_i(pend), .fiq_sel_i(fsel), .status_o(status)
  );

  task automatic check(input logic [31:0] exp, input string req);
    n_chk++;
    if (status !== exp) begin
      n_bad++;
      $display("FAIL %s: status=%h expected=%h", req, status, exp);
    end
  endtask

  task automatic clear_all();
    vld = '0; ids = '0; pend = '0; fsel = '0;
  endtask

  task automatic put(input int slot, input logic v, input logic [5:0] id);
    vld[slot] = v;
    ids[slot*6 +: 6] = id;
  endtask

  // wait for the registered result: one rising edge, then sample at falling edge
  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] model();
    logic ff = 0, fi = 0;
    logic [5:0] fid = 6'h3F, iid = 6'h3F;
    for (int i = 0; i < NS; i++) begin
      logic [5:0] id = ids[i*6 +: 6];
      if (vld[i] && id < NR && pend[id]) begin
        if (fsel[id] && !ff) begin ff = 1; fid = id; end
        if (!fsel[id] && !fi) begin fi = 1; iid = id; end
      end
    end
    return {fi, 9'd0, iid, ff, 9'd0, fid};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(32'h003F003F, "R8 reset value");
    rst_n = 1'b1;
    settle();
    check(32'h003F003F, "R6 idle after reset");
  endtask

  task automatic t_no_pending();
    clear_all();
    for (int i = 0; i < NS; i++) put(i, 1'b1, 6'(i));
    fsel = 40'hFF_0000_FFFF;
    settle();
    check(32'h003F003F, "R6 nothing pending");
  endtask

  task automatic t_single_fiq();
    clear_all();
    put(7, 1'b1, 6'd12); pend[12] = 1'b1; fsel[12] = 1'b1;
    settle();
    check(32'h003F800C, "R4 R3 single fiq");
  endtask

  task automatic t_single_irq();
    clear_all();
    put(7, 1'b1, 6'd12); pend[12] = 1'b1;
    settle();
    check(32'h800C003F, "R5 R3 single irq");
    pend[12] = 1'b0; // enabled-pending cleared: no winner
    settle();
    check(32'h003F003F, "R3 not pending");
  endtask

  task automatic t_rank_order();
    clear_all();
    put(3, 1'b1, 6'd20); put(10, 1'b1, 6'd5);
    pend[20] = 1'b1; pend[5] = 1'b1;
    settle();
    check(32'h8014003F, "R2 lower slot wins");
    fsel[20] = 1'b1;
    settle();
    check(32'h80058014, "R2 classes independent");
    put(39, 1'b1, 6'd39); pend[39] = 1'b1; fsel[39] = 1'b1;
    put(3, 1'b0, 6'd20);
    settle();
    check(32'h80058027, "R2 last slot reachable");
  endtask

  task automatic t_skip_slots();
    clear_all();
    pend = '1;
    put(0, 1'b0, 6'd1);   // flag clear
    put(1, 1'b1, 6'd45);  // ID beyond sources
    put(2, 1'b1, 6'd63);
    put(3, 1'b1, 6'd40);
    put(4, 1'b1, 6'd2);
    settle();
    check(32'h8002003F, "R1 invalid slots skipped");
  endtask

  task automatic t_duplicate();
    clear_all();
    put(5, 1'b1, 6'd9); put(2, 1'b1, 6'd9); put(4, 1'b1, 6'd30);
    pend[9] = 1'b1; pend[30] = 1'b1;
    settle();
    check(32'h8009003F, "R2 duplicate id ranks at lowest slot");
  endtask

  task automatic t_latency();
    clear_all();
    put(0, 1'b1, 6'd33); pend[33] = 1'b1;
    settle();
    check(32'h8021003F, "R8 first value");
    pend[33] = 1'b0; fsel[33] = 1'b1; pend[17] = 1'b1; put(1, 1'b1, 6'd17); fsel[17] = 1'b1;
    #2;
    check(32'h8021003F, "R8 held before edge");
    settle();
    check(32'h003F8011, "R8 updated after edge");
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      logic [31:0] exp;
      for (int i = 0; i < NS; i++)
        put(i, ($urandom_range(0, 3) != 0), 6'($urandom_range(0, 47)));
      pend = {$urandom, $urandom};
      fsel = {$urandom, $urandom};
      if (n % 4 == 0) pend = pend & {$urandom, $urandom} & {$urandom, $urandom};
      exp = model();
      settle();
      check(exp, "R2 R3 R7 random table");
      if (status[14:6] != 0 || status[30:22] != 0) begin
        n_bad++;
        $display("FAIL R7: status=%h expected gap bits zero", status);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_no_pending();
    t_single_fiq();
    t_single_irq();
    t_rank_order();
    t_skip_slots();
    t_duplicate();
    t_latency();
    t_random();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: status=%h expected=run completion", status);
    finish_run();
  end
endmodule